// File: doc/BRIEF.md
# Runtime-Configurable Approximate Ripple Adder/Subtractor

This block adds or subtracts two 32-bit operands through a ripple chain of dual-mode full-adder cells. Every cell can run in one of two modes. In exact mode it is an ordinary full adder. In approximate mode it ignores its incoming carry. Its sum output then copies the operand B bit, taken after the subtract inversion, and its carry output copies the operand A bit. Each cell selects between the two results with an output multiplexer.

A small controller turns a degree value k into a thermometer mask. The mask puts the k least significant cells into approximate mode and leaves the rest exact. Pass-through is used rather than forcing low bits to zero, so an approximate bit still matches the exact answer for many inputs. The exact logic of each approximate cell is reported as gated off through a per-cell enable flag. A caller lowers k when it needs full precision and raises k to trade low-order accuracy for less switching.

Top module: `dmx_addsub`

## Requirements
- R1: With degree 0 and subtract low, {carry_o, result_o} equals the full 33-bit unsigned sum of op_a_i and op_b_i.
- R2: With degree 0 and subtract high, result_o equals op_a_i minus op_b_i modulo 2^32. carry_o is the raw carry of the inverted-B addition, which is 1 exactly when op_a_i >= op_b_i as unsigned values.
- R3: In every approximate cell i (i < k), result bit i equals op_b_i[i] XOR sub_i and does not depend on the incoming carry.
- R4: The carry leaving an approximate cell i equals op_a_i[i]. So with 0 < k < 32, cell k receives op_a_i[k-1] as its carry-in, and with k = 32 carry_o equals op_a_i[31].
- R5: Cells i >= k act as full adders: sum = a ^ b' ^ cin and carry = majority(a, b', cin), where b' is the B bit after the subtract inversion and cell 0's carry-in is sub_i.
- R6: The controller sets exactly min(k, 32) mode bits, all contiguous from bit 0. Any degree above 32 acts as 32.
- R7: With degree 32 or more, result_o equals op_b_i XOR {32{sub_i}} regardless of op_a_i.
- R8: exact_en_o[i] is 1 exactly for the cells running in exact mode, and 0 for the cells running in approximate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B (inverted internally when subtracting) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| degree_i | input | 6 | Number of low-order cells in approximate mode (0..63, saturated at 32) |
| result_o | output | 32 | Sum or difference |
| carry_o | output | 1 | Carry out of the most significant cell |
| exact_en_o | output | 32 | Per-cell enable flag of the exact adder logic |

## Verification
The bench uses the default parameters: a 32-bit datapath and a 6-bit degree. These widths let it reach every degree from 0 through 32 and also the saturating values 33 to 63. Random operands with random k are compared bit by bit against an independent loop model of the approximation rule. Directed cases cover exact add and subtract with carry and borrow, full approximation, and the boundary cell just above the approximate region. That boundary cell's carry-in must come from operand A.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  // Exact full-adder sum bit
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Exact full-adder carry bit (majority)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Clamp a degree value to the datapath width
  function automatic int unsigned clamp_degree(input int unsigned k, input int unsigned w);
    return (k > w) ? w : k;
  endfunction
endpackage

// File: rtl/dmx_ctrl.sv
module dmx_ctrl #(
  parameter int WIDTH = 32,
  parameter int KW    = $clog2(WIDTH + 1)
) (
  input  logic [KW-1:0]    degree_i,
  output logic [WIDTH-1:0] approx_o
);
  import dmx_pkg::*;

  logic [KW-1:0] k_sat;
  assign k_sat = KW'(clamp_degree(int'(degree_i), WIDTH));

  for (genvar i = 0; i < WIDTH; i++) begin : g_therm
    assign approx_o[i] = (k_sat > KW'(i));
  end

  // R6: mask contiguous from bit 0 and of the saturated population
  always_comb begin
    p_therm_shape_r6: assert (((approx_o + 1'b1) & approx_o) == '0)
      else $error("mask not contiguous from bit 0");
    p_therm_count_r6: assert ($countones(approx_o) == clamp_degree(int'(degree_i), WIDTH))
      else $error("mask population mismatch");
  end
endmodule

// File: rtl/dmx_cell.sv
module dmx_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic approx_i,
  output logic sum_o,
  output logic cout_o,
  output logic exact_en_o
);
  import dmx_pkg::*;

  logic ex_sum, ex_carry;

  // Exact path is enabled (not gated) only in exact mode
  assign exact_en_o = ~approx_i;
  assign ex_sum     = exact_en_o ? fa_sum(a_i, b_i, cin_i)   : 1'b0;
  assign ex_carry   = exact_en_o ? fa_carry(a_i, b_i, cin_i) : 1'b0;

  // Output mode multiplexers
  assign sum_o  = approx_i ? b_i : ex_sum;
  assign cout_o = approx_i ? a_i : ex_carry;
endmodule

// File: rtl/dmx_chain.sv
module dmx_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] approx_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [WIDTH-1:0] exact_en_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;
  assign cout_o   = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dmx_cell u_cell (
      .a_i        (a_i[i]),
      .b_i        (b_i[i]),
      .cin_i      (carry[i]),
      .approx_i   (approx_i[i]),
      .sum_o      (sum_o[i]),
      .cout_o     (carry[i+1]),
      .exact_en_o (exact_en_o[i])
    );
  end

  // R4 / R8: relations between controller mask, cell flags and ripple wires
  always_comb begin
    p_gate_flag_r8: assert (exact_en_o == ~approx_i)
      else $error("exact enable disagrees with mode mask");
    for (int i = 0; i < WIDTH; i++) begin
      if (approx_i[i]) begin
        p_pass_carry_r4: assert (carry[i+1] == a_i[i])
          else $error("approximate carry not taken from A");
        p_pass_sum_r3: assert (sum_o[i] == b_i[i])
          else $error("approximate sum not taken from B");
      end
    end
  end
endmodule

// File: rtl/dmx_addsub.sv
module dmx_addsub #(
  parameter int WIDTH = 32,
  parameter int KW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             sub_i,
  input  logic [KW-1:0]    degree_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic [WIDTH-1:0] exact_en_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] approx_mask;

  assign b_eff = op_b_i ^ {WIDTH{sub_i}};

  dmx_ctrl #(.WIDTH(WIDTH), .KW(KW)) u_ctrl (
    .degree_i (degree_i),
    .approx_o (approx_mask)
  );

  dmx_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i        (op_a_i),
    .b_i        (b_eff),
    .cin_i      (sub_i),
    .approx_i   (approx_mask),
    .sum_o      (result_o),
    .cout_o     (carry_o),
    .exact_en_o (exact_en_o)
  );

  // R1 / R2: degree 0 reproduces exact two's-complement arithmetic
  always_comb begin
    if (degree_i == '0) begin
      p_exact_arith_r1: assert ({carry_o, result_o} ==
          ({1'b0, op_a_i} + {1'b0, op_b_i ^ {WIDTH{sub_i}}} + {{WIDTH{1'b0}}, sub_i}))
        else $error("degree 0 result not exact");
    end
    if (int'(degree_i) >= WIDTH) begin
      p_full_pass_r7: assert (result_o == (op_b_i ^ {WIDTH{sub_i}}))
        else $error("full approximation result wrong");
    end
  end
endmodule

// File: tb/tb_dmx_addsub.sv
module tb_dmx_addsub;
  localparam int W  = 32;
  localparam int KW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  a, b;
  logic          sub;
  logic [KW-1:0] k;
  logic [W-1:0]  res, en;
  logic          cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dmx_addsub dut (
    .op_a_i(a), .op_b_i(b), .sub_i(sub), .degree_i(k),
    .result_o(res), .carry_o(cout), .exact_en_o(en)
  );

  // Independent bit-serial model of the approximation rule
  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic s, input int kk);
    logic [W-1:0] r;
    logic c, yb;
    int lim;
    lim = (kk > W) ? W : kk;
    c = s;
    for (int i = 0; i < W; i++) begin
      yb = y[i] ^ s;
      if (i < lim) begin
        r[i] = yb;
        c = x[i];
      end else begin
        r[i] = x[i] ^ yb ^ c;
        c = (x[i] + yb + c) > 1;
      end
    end
    return {c, r};
  endfunction

  function automatic logic [W-1:0] en_model(input int kk);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = !(i < kk);
    return m;
  endfunction

  task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h (a=%h b=%h sub=%0d k=%0d)", tag, got, exp, a, b, sub, k);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic s, input int kk);
    @(negedge clk);
    a = x; b = y; sub = s; k = KW'(kk);
    @(posedge clk);
    #1;
  endtask

  task automatic full_check(input string tag);
    logic [W:0] e;
    e = model(a, b, sub, int'(k));
    chk({tag, " R5 result"}, {1'b0, res}, {1'b0, e[W-1:0]});
    chk({tag, " R4 carry"},  {{W{1'b0}}, cout}, {{W{1'b0}}, e[W]});
    chk({tag, " R8 enable"}, {1'b0, en}, {1'b0, en_model(int'(k))});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W:0] e;
    int seed_dummy;
    a = '0; b = '0; sub = 1'b0; k = '0;
    // initial state: all-zero inputs give zero outputs, all cells exact
    drive('0, '0, 1'b0, 0);
    chk("R1 idle", {cout, res}, '0);
    chk("R8 idle enable", {1'b0, en}, {1'b0, {W{1'b1}}});

    // R1: exact addition with carry out
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 0);
    chk("R1 wrap", {cout, res}, {1'b1, 32'h0});
    drive(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 0);
    chk("R1 add", {cout, res}, {1'b0, 32'h1234_5678} + {1'b0, 32'h9ABC_DEF0});

    // R2: exact subtraction, no borrow and borrow
    drive(32'd100, 32'd30, 1'b1, 0);
    chk("R2 sub", {cout, res}, {1'b1, 32'd70});
    drive(32'd30, 32'd100, 1'b1, 0);
    chk("R2 borrow", {cout, res}, {1'b0, 32'hFFFF_FFBA});

    // R3: approximate low bits follow B' irrespective of carries below
    drive(32'h0000_00FF, 32'h0000_0001, 1'b0, 8);
    chk("R3 low pass", {25'h0, res[7:0]}, {25'h0, 8'h01});
    drive(32'h0000_00FF, 32'h0000_0001, 1'b1, 8);
    chk("R3 low pass sub", {25'h0, res[7:0]}, {25'h0, 8'hFE});

    // R4: boundary cell takes its carry-in from A[k-1]
    drive(32'h0000_0008, 32'h0, 1'b0, 4);
    chk("R4 boundary one", {1'b0, res}, {1'b0, 32'h0000_0010});
    drive(32'h0000_0007, 32'h0, 1'b0, 4);
    chk("R4 boundary zero", {1'b0, res}, {1'b0, 32'h0});

    // R7: full approximation and R6 saturation
    drive(32'h8000_0000, 32'hA5A5_0F0F, 1'b0, 32);
    chk("R7 full", {cout, res}, {1'b1, 32'hA5A5_0F0F});
    drive(32'h0, 32'hA5A5_0F0F, 1'b1, 32);
    chk("R7 full sub", {cout, res}, {1'b0, 32'h5A5A_F0F0});
    drive(32'h1111_1111, 32'h2222_2222, 1'b0, 45);
    chk("R6 saturate", {cout, res}, {1'b0, 32'h2222_2222});
    chk("R6 saturate enable", {1'b0, en}, '0);
    drive(32'h1111_1111, 32'h2222_2222, 1'b0, 63);
    chk("R6 max", {1'b0, en}, '0);

    // every degree with a fixed pattern
    for (int kk = 0; kk <= 33; kk++) begin
      drive(32'hDEAD_BEEF, 32'h0F1E_2D3C, kk[0], kk);
      full_check("R6 sweep");
    end

    // constrained random
    seed_dummy = $urandom(32'hC0FFEE);
    for (int n = 0; n < 3000; n++) begin
      int kk;
      kk = (n % 4 == 0) ? 0 : int'($urandom_range(0, 40));
      drive($urandom, $urandom, 1'($urandom), kk);
      full_check("R5 random");
      if (kk == 0) begin
        e = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
        chk("R1 R2 random exact", {cout, res}, e);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule